// File: doc/BRIEF.md
# Exception Pending and Fault Escalation Controller

This block holds the pending and enable state for the exception numbers of a processor core. Numbers 0 to 15 are system exceptions. Numbers 16 and up belong to external interrupt lines, and line n maps to number 16+n. A pending bit is set by a rising edge on a system request line, on an external line or on a fault-cause line. Software-style pulse vectors can also set or clear pending bits and enable bits.

Fault causes collect in a sticky cause register. A configurable fault class that is pending while disabled is converted into a pending HardFault, and a forced flag is set. A single request output tells the core that some exception is both pending and enabled. A one-cycle wake pulse is raised on an event edge, or when an external interrupt newly pends while send-event-on-pend is set.

Priority arbitration, vector fetch and stacking are left to the core.

Top module: `exc_pend_ctl`

## Requirements
- R1: After reset, all pending bits are 0, the cause register is 0, the forced flag is 0, and `irq_o` and `wake_o` are 0. The enable bits are set for numbers 1 (Reset), 2 (NMI), 3 (HardFault), 11 (SVCall), 12 (DebugMonitor), 14 (PendSV) and 15 (SysTick). All other enable bits are 0, which includes 4 (MemManage), 5 (BusFault), 6 (UsageFault) and every external number.
- R2: A 0-to-1 transition on `sys_req_i[k]` sets pending bit k, for k in {2,3,4,5,6,11,12,14,15}. A 0-to-1 transition on `ext_irq_i[n]` sets pending bit 16+n. A level held high does not set the bit again. Request bits 0, 1, 7 to 10 and 13 are ignored, and those pending bits stay 0.
- R3: In a given cycle, a 1 in `pend_clr_i` clears the matching pending bit and a 1 in `pend_set_i` sets it. When a set (from `pend_set_i` or from an edge) and a clear hit the same bit in the same cycle, the set wins.
- R4: A 1 in `en_set_i` sets the matching enable bit and a 1 in `en_clr_i` clears it. Enable bits 1 to 3 cannot be cleared.
- R5: Each rising edge on `fault_cause_i[b]` sets bit b of `cause_o`. Bits 7:0 pend MemManage (4), bits 15:8 pend BusFault (5), and bits 31:16 pend UsageFault (6). A 1 in `cause_clr_i` clears the matching cause bit, and a new edge in the same cycle wins. Cause bits change only through these two paths.
- R6: If pending bit 4, 5 or 6 would be set while its enable bit is 0, that pending bit is cleared instead. In the same cycle, HardFault pending bit 3 and `hf_forced_o` are set. `hf_forced_clr_i` clears the forced flag.
- R7: `irq_o` is 1 exactly when some exception number has both its pending and enable bits set. The only exception is the cycle covered by R8.
- R8: A rising edge on `event_i` makes `wake_o` 1 for one cycle. In that cycle `irq_o` keeps its previous value.
- R9: When `sev_on_pend_i` is 1 and an external line rises while its pending bit is 0, `wake_o` is 1 for one cycle. There is no pulse if that bit was already pending or if `sev_on_pend_i` is 0.
- R10: All outputs are registered. They reflect inputs sampled at a clock edge immediately after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sys_req_i | input | 16 | System exception request lines, bit = exception number |
| ext_irq_i | input | NUM_EXT | External interrupt lines |
| fault_cause_i | input | 32 | Fault cause lines, split by class |
| event_i | input | 1 | Event input, rising edge wakes |
| sev_on_pend_i | input | 1 | Wake when an external interrupt newly pends |
| pend_set_i | input | NUM_EXT+16 | Pending set pulses |
| pend_clr_i | input | NUM_EXT+16 | Pending clear pulses |
| en_set_i | input | NUM_EXT+16 | Enable set pulses |
| en_clr_i | input | NUM_EXT+16 | Enable clear pulses |
| cause_clr_i | input | 32 | Cause register write-1-to-clear |
| hf_forced_clr_i | input | 1 | Clears the forced flag |
| pending_o | output | NUM_EXT+16 | Pending bits |
| enable_o | output | NUM_EXT+16 | Enable bits |
| cause_o | output | 32 | Sticky fault cause register |
| hf_forced_o | output | 1 | HardFault forced flag |
| irq_o | output | 1 | Request to the core |
| wake_o | output | 1 | Wake pulse |

## Verification
The bench holds a request line high after software clears its pending bit. An edge detector that acts on levels would re-pend the bit at once. It raises a BusFault cause while BusFault is disabled; a design that skips the escalation leaves bit 5 pending and never sets the HardFault bit or the forced flag. It also disables MemManage while it is already pending, which catches escalation that only looks at newly arriving requests.

Two same-cycle collisions are exercised. The first is a set and a clear on one pending bit. The second is an event edge together with a new pend: a design that updates `irq_o` on that cycle would be seen raising it one cycle early.

The send-event-on-pend wake is tested on an already-pending line and with the control low. Either case exposes a design that wakes on every external edge.

// File: rtl/exc_pkg.sv
package exc_pkg;
    localparam int SYS_CNT   = 16;
    localparam int EXC_RESET = 1;
    localparam int EXC_NMI   = 2;
    localparam int EXC_HARD  = 3;
    localparam int EXC_MEM   = 4;
    localparam int EXC_BUS   = 5;
    localparam int EXC_USAGE = 6;
    localparam int CFG_FAULTS = 3;

    // exception numbers that may pend: 2..6, 11, 12, 14, 15
    localparam logic [SYS_CNT-1:0] SYS_PEND_OK  = 16'hD87C;
    // exception numbers that carry an enable bit (adds Reset)
    localparam logic [SYS_CNT-1:0] SYS_EN_OK    = 16'hD87E;
    localparam logic [SYS_CNT-1:0] SYS_EN_RST   = 16'hD80E;
    localparam logic [SYS_CNT-1:0] SYS_EN_FIXED = 16'h000E;

    localparam int CAUSE_W = 32;
    localparam int MEM_LO = 0,  MEM_HI = 7;
    localparam int BUS_LO = 8,  BUS_HI = 15;
    localparam int USE_LO = 16, USE_HI = 31;
endpackage

// File: rtl/exc_edge_det.sv
module exc_edge_det #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sig_i,
    output logic [W-1:0] rise_o
);
    logic [W-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = sig_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    assign rise_o = sig_i & ~prev_q;
endmodule

// File: rtl/exc_fault_status.sv
module exc_fault_status
    import exc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CAUSE_W-1:0] cause_i,
    input  logic [CAUSE_W-1:0] clr_i,
    output logic [CAUSE_W-1:0] cause_o,
    output logic [2:0]         class_req_o
);
    logic [CAUSE_W-1:0] rise;
    logic [CAUSE_W-1:0] cause_d, cause_q;

    exc_edge_det #(.W(CAUSE_W)) u_cause_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  (cause_i),
        .rise_o (rise)
    );

    always_comb begin
        cause_d = (cause_q & ~clr_i) | rise;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cause_q <= '0;
        else        cause_q <= cause_d;
    end

    assign cause_o        = cause_q;
    assign class_req_o[0] = |rise[MEM_HI:MEM_LO];
    assign class_req_o[1] = |rise[BUS_HI:BUS_LO];
    assign class_req_o[2] = |rise[USE_HI:USE_LO];
endmodule

// File: rtl/exc_escalate.sv
module exc_escalate
    import exc_pkg::*;
#(
    parameter int N = 48
) (
    input  logic [N-1:0] pend_i,
    input  logic [N-1:0] en_i,
    output logic [N-1:0] pend_o,
    output logic         esc_o
);
    logic [CFG_FAULTS-1:0] hit;

    for (genvar k = 0; k < CFG_FAULTS; k++) begin : g_cfg
        assign hit[k] = pend_i[EXC_MEM+k] & ~en_i[EXC_MEM+k];
    end

    always_comb begin
        pend_o = pend_i;
        for (int k = 0; k < CFG_FAULTS; k++) begin
            if (hit[k]) pend_o[EXC_MEM+k] = 1'b0;
        end
        if (|hit) pend_o[EXC_HARD] = 1'b1;
    end

    assign esc_o = |hit;
endmodule

// File: rtl/exc_pend_ctl.sv
module exc_pend_ctl
    import exc_pkg::*;
#(
    parameter int NUM_EXT = 32,
    localparam int NUM_EXC = SYS_CNT + NUM_EXT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SYS_CNT-1:0] sys_req_i,
    input  logic [NUM_EXT-1:0] ext_irq_i,
    input  logic [CAUSE_W-1:0] fault_cause_i,
    input  logic               event_i,
    input  logic               sev_on_pend_i,
    input  logic [NUM_EXC-1:0] pend_set_i,
    input  logic [NUM_EXC-1:0] pend_clr_i,
    input  logic [NUM_EXC-1:0] en_set_i,
    input  logic [NUM_EXC-1:0] en_clr_i,
    input  logic [CAUSE_W-1:0] cause_clr_i,
    input  logic               hf_forced_clr_i,
    output logic [NUM_EXC-1:0] pending_o,
    output logic [NUM_EXC-1:0] enable_o,
    output logic [CAUSE_W-1:0] cause_o,
    output logic               hf_forced_o,
    output logic               irq_o,
    output logic               wake_o
);
    localparam logic [NUM_EXC-1:0] PEND_OK  = {{NUM_EXT{1'b1}}, SYS_PEND_OK};
    localparam logic [NUM_EXC-1:0] EN_OK    = {{NUM_EXT{1'b1}}, SYS_EN_OK};
    localparam logic [NUM_EXC-1:0] EN_RST   = {{NUM_EXT{1'b0}}, SYS_EN_RST};
    localparam logic [NUM_EXC-1:0] EN_FIXED = {{NUM_EXT{1'b0}}, SYS_EN_FIXED};

    typedef struct packed {
        logic [NUM_EXC-1:0] pend;
        logic [NUM_EXC-1:0] en;
        logic               forced;
        logic               irq;
        logic               wake;
    } state_t;

    state_t st_d, st_q;

    logic [SYS_CNT-1:0] sys_rise;
    logic [NUM_EXT-1:0] ext_rise;
    logic               ev_rise;
    logic [2:0]         class_req;
    logic [NUM_EXC-1:0] fault_pend;
    logic [NUM_EXC-1:0] en_nx;
    logic [NUM_EXC-1:0] pend_mid;
    logic [NUM_EXC-1:0] pend_fin;
    logic               esc;

    exc_edge_det #(.W(SYS_CNT)) u_sys_edge (
        .clk(clk), .rst_n(rst_n), .sig_i(sys_req_i), .rise_o(sys_rise)
    );

    exc_edge_det #(.W(NUM_EXT)) u_ext_edge (
        .clk(clk), .rst_n(rst_n), .sig_i(ext_irq_i), .rise_o(ext_rise)
    );

    exc_edge_det #(.W(1)) u_ev_edge (
        .clk(clk), .rst_n(rst_n), .sig_i(event_i), .rise_o(ev_rise)
    );

    exc_fault_status u_fault (
        .clk         (clk),
        .rst_n       (rst_n),
        .cause_i     (fault_cause_i),
        .clr_i       (cause_clr_i),
        .cause_o     (cause_o),
        .class_req_o (class_req)
    );

    always_comb begin
        fault_pend = '0;
        for (int k = 0; k < CFG_FAULTS; k++) begin
            fault_pend[EXC_MEM+k] = class_req[k];
        end
    end

    // clear first, then every set source, so a set wins a same-cycle clash
    assign en_nx    = ((st_q.en & ~en_clr_i) | en_set_i | EN_FIXED) & EN_OK;
    assign pend_mid = ((st_q.pend & ~pend_clr_i) | pend_set_i | fault_pend
                      | {ext_rise, sys_rise}) & PEND_OK;

    exc_escalate #(.N(NUM_EXC)) u_esc (
        .pend_i (pend_mid),
        .en_i   (en_nx),
        .pend_o (pend_fin),
        .esc_o  (esc)
    );

    always_comb begin
        st_d        = st_q;
        st_d.en     = en_nx;
        st_d.pend   = pend_fin;
        st_d.forced = (st_q.forced & ~hf_forced_clr_i) | esc;
        st_d.wake   = ev_rise
                    | (sev_on_pend_i & |(ext_rise & ~st_q.pend[NUM_EXC-1:SYS_CNT]));
        st_d.irq    = ev_rise ? st_q.irq : |(pend_fin & en_nx);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.en     <= EN_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign pending_o   = st_q.pend;
    assign enable_o    = st_q.en;
    assign hf_forced_o = st_q.forced;
    assign irq_o       = st_q.irq;
    assign wake_o      = st_q.wake;
endmodule

// File: rtl/exc_pend_ctl_chk.sv
module exc_pend_ctl_chk
    import exc_pkg::*;
#(
    parameter int NUM_EXT = 32,
    localparam int NUM_EXC = SYS_CNT + NUM_EXT
) (
    input logic               clk,
    input logic               rst_n,
    input logic               event_i,
    input logic [CAUSE_W-1:0] cause_clr_i,
    input logic [NUM_EXC-1:0] pending_o,
    input logic [NUM_EXC-1:0] enable_o,
    input logic [CAUSE_W-1:0] cause_o,
    input logic               hf_forced_o,
    input logic               irq_o,
    input logic               wake_o
);
    logic ev_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ev_prev <= 1'b0;
        else        ev_prev <= event_i;
    end

    p_unused_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_o[SYS_CNT-1:0] & ~SYS_PEND_OK) == '0);

    p_fixed_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
        enable_o[EXC_HARD:EXC_RESET] == 3'b111);

    p_cause_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cause_o) & ~cause_o & ~$past(cause_clr_i)) == '0);

    p_no_disabled_cfg_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_o[EXC_USAGE:EXC_MEM] & ~enable_o[EXC_USAGE:EXC_MEM]) == '0);

    p_forced_hard_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hf_forced_o) |-> pending_o[EXC_HARD]);

    p_irq_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(irq_o) |-> (irq_o == |(pending_o & enable_o)));

    p_event_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (event_i && !ev_prev) |=> (wake_o && $stable(irq_o)));
endmodule

bind exc_pend_ctl exc_pend_ctl_chk #(.NUM_EXT(NUM_EXT)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .event_i     (event_i),
    .cause_clr_i (cause_clr_i),
    .pending_o   (pending_o),
    .enable_o    (enable_o),
    .cause_o     (cause_o),
    .hf_forced_o (hf_forced_o),
    .irq_o       (irq_o),
    .wake_o      (wake_o)
);

// File: tb/exc_pend_ctl_bench.sv
module exc_pend_ctl_bench;
    localparam int NE = 32;
    localparam int NX = 16 + NE;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [15:0]   sys_req_i = '0;
    logic [NE-1:0] ext_irq_i = '0;
    logic [31:0]   fault_cause_i = '0;
    logic          event_i = 1'b0;
    logic          sev_on_pend_i = 1'b0;
    logic [NX-1:0] pend_set_i = '0;
    logic [NX-1:0] pend_clr_i = '0;
    logic [NX-1:0] en_set_i = '0;
    logic [NX-1:0] en_clr_i = '0;
    logic [31:0]   cause_clr_i = '0;
    logic          hf_forced_clr_i = 1'b0;
    logic [NX-1:0] pending_o, enable_o;
    logic [31:0]   cause_o;
    logic          hf_forced_o, irq_o, wake_o;

    int n_run = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    exc_pend_ctl #(.NUM_EXT(NE)) u_exc_pend_ctl (
        .clk(clk), .rst_n(rst_n), .sys_req_i(sys_req_i), .ext_irq_i(ext_irq_i),
        .fault_cause_i(fault_cause_i), .event_i(event_i),
        .sev_on_pend_i(sev_on_pend_i), .pend_set_i(pend_set_i),
        .pend_clr_i(pend_clr_i), .en_set_i(en_set_i), .en_clr_i(en_clr_i),
        .cause_clr_i(cause_clr_i), .hf_forced_clr_i(hf_forced_clr_i),
        .pending_o(pending_o), .enable_o(enable_o), .cause_o(cause_o),
        .hf_forced_o(hf_forced_o), .irq_o(irq_o), .wake_o(wake_o)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [NX-1:0] bx(input int i);
        return NX'(1) << i;
    endfunction

    task automatic t_reset();
        chk("R1 pending", 64'(pending_o), 64'h0);
        chk("R1 enable", 64'(enable_o), 64'hD80E);
        chk("R1 cause", 64'(cause_o), 64'h0);
        chk("R1 forced", 64'(hf_forced_o), 64'h0);
        chk("R1 irq", 64'(irq_o), 64'h0);
        chk("R1 wake", 64'(wake_o), 64'h0);
    endtask

    task automatic t_sys_edge();
        sys_req_i = 16'h8081;
        tick();
        chk("R2 sys edge pends 15 only", 64'(pending_o), 64'h8000);
        chk("R7 irq on enabled pend", 64'(irq_o), 64'h1);
        pend_clr_i = bx(15);
        tick();
        pend_clr_i = '0;
        chk("R2 held level no repend", 64'(pending_o), 64'h0);
        chk("R7 irq drops", 64'(irq_o), 64'h0);
        tick();
        chk("R2 still clear", 64'(pending_o), 64'h0);
        sys_req_i = '0;
        tick();
    endtask

    task automatic t_ext();
        ext_irq_i = 32'h20;
        tick();
        chk("R2 ext line 5 -> 21", 64'(pending_o), 64'h20_0000);
        chk("R7 disabled no irq", 64'(irq_o), 64'h0);
        en_set_i = bx(21);
        tick();
        en_set_i = '0;
        chk("R4 enable set", 64'(enable_o), 64'h20_D80E);
        chk("R7 irq after enable", 64'(irq_o), 64'h1);
        en_clr_i = bx(21);
        tick();
        en_clr_i = '0;
        chk("R4 enable clear", 64'(enable_o), 64'hD80E);
        chk("R7 irq after disable", 64'(irq_o), 64'h0);
        pend_clr_i = bx(21);
        ext_irq_i = '0;
        tick();
        pend_clr_i = '0;
        chk("R3 ext clear", 64'(pending_o), 64'h0);
    endtask

    task automatic t_sw_pend();
        pend_set_i = bx(14);
        tick();
        chk("R3 sw set", 64'(pending_o), 64'h4000);
        pend_clr_i = bx(14);
        tick();
        pend_set_i = '0;
        chk("R3 set wins clash", 64'(pending_o), 64'h4000);
        tick();
        pend_clr_i = '0;
        chk("R3 sw clear", 64'(pending_o), 64'h0);
    endtask

    task automatic t_enable_fixed();
        en_clr_i = '1;
        tick();
        en_clr_i = '0;
        chk("R4 fixed enables survive", 64'(enable_o), 64'hE);
        en_set_i = 48'hD800;
        tick();
        en_set_i = '0;
        chk("R4 restore", 64'(enable_o), 64'hD80E);
    endtask

    task automatic t_fault();
        en_set_i = bx(4);
        tick();
        en_set_i = '0;
        fault_cause_i = 32'h4;
        tick();
        chk("R5 cause bit2", 64'(cause_o), 64'h4);
        chk("R5 memmanage pends", 64'(pending_o), 64'h10);
        chk("R6 no force when enabled", 64'(hf_forced_o), 64'h0);
        fault_cause_i = 32'h204;
        tick();
        chk("R5 cause accumulates", 64'(cause_o), 64'h204);
        chk("R6 busfault escalated", 64'(pending_o), 64'h18);
        chk("R6 forced set", 64'(hf_forced_o), 64'h1);
        chk("R7 irq with hardfault", 64'(irq_o), 64'h1);
        cause_clr_i = 32'h4;
        tick();
        cause_clr_i = '0;
        chk("R5 w1c, held line no reset", 64'(cause_o), 64'h200);
        hf_forced_clr_i = 1'b1;
        tick();
        hf_forced_clr_i = 1'b0;
        chk("R6 forced clear", 64'(hf_forced_o), 64'h0);
        fault_cause_i = '0;
        pend_clr_i = bx(3);
        tick();
        pend_clr_i = '0;
        en_clr_i = bx(4);
        tick();
        en_clr_i = '0;
        chk("R6 disable pending memmanage", 64'(pending_o), 64'h8);
        chk("R6 forced by disable", 64'(hf_forced_o), 64'h1);
        pend_clr_i = bx(3);
        hf_forced_clr_i = 1'b1;
        cause_clr_i = '1;
        tick();
        pend_clr_i = '0;
        hf_forced_clr_i = 1'b0;
        cause_clr_i = '0;
        chk("R5 all cleared", 64'(cause_o), 64'h0);
    endtask

    task automatic t_event();
        event_i = 1'b1;
        pend_set_i = bx(15);
        tick();
        pend_set_i = '0;
        chk("R8 wake on event", 64'(wake_o), 64'h1);
        chk("R8 irq held", 64'(irq_o), 64'h0);
        chk("R10 pend updated", 64'(pending_o), 64'h8000);
        tick();
        chk("R8 wake one cycle", 64'(wake_o), 64'h0);
        chk("R7 irq next cycle", 64'(irq_o), 64'h1);
        event_i = 1'b0;
        pend_clr_i = bx(15);
        tick();
        pend_clr_i = '0;
        chk("R7 irq clear", 64'(irq_o), 64'h0);
    endtask

    task automatic t_sev();
        sev_on_pend_i = 1'b1;
        ext_irq_i = 32'h8;
        tick();
        chk("R9 wake on new pend", 64'(wake_o), 64'h1);
        chk("R9 pend 19", 64'(pending_o), 64'h8_0000);
        tick();
        chk("R9 pulse ends", 64'(wake_o), 64'h0);
        ext_irq_i = '0;
        tick();
        ext_irq_i = 32'h8;
        tick();
        chk("R9 no wake already pending", 64'(wake_o), 64'h0);
        sev_on_pend_i = 1'b0;
        ext_irq_i = 32'h18;
        tick();
        chk("R9 no wake control low", 64'(wake_o), 64'h0);
        chk("R9 line 4 pended", 64'(pending_o), 64'h18_0000);
        ext_irq_i = '0;
        pend_clr_i = '1;
        tick();
        pend_clr_i = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

    initial begin
        #1;
        tick();
        t_reset();
        tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_sys_edge();
        t_ext();
        t_sw_pend();
        t_enable_fixed();
        t_fault();
        t_event();
        t_sev();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end
endmodule